// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a small fully associative branch target buffer placed beside the fetch program counter. In every cycle the fetch address is compared against the tag of every entry at once. The result is a three-way prediction: no prediction (fall through to the next sequential address), taken with no known target, or taken with a stored target. A valid entry whose stored target is all zeros stands for a transfer that is known to be taken but whose destination is not held. Such an entry lets a later stage compute the destination.

Resolved branches and jumps report back through an update port carrying the instruction address, the resolved direction and the resolved destination. Reports from killed instructions are discarded. A taken report that matches no entry allocates one. Free entries are used before any live entry is evicted, and eviction follows a rotating pointer. A separate load port writes any entry directly so a test can start from known contents.

Top module: `btb_fa`

## Requirements
- R1: After reset every entry is invalid, so any lookup yields `pred_kind` 00 (no prediction) and `pred_next_pc` equal to `fetch_pc`+4.
- R2: A fetch address that equals no stored tag yields `pred_kind` 00 and `pred_next_pc` = `fetch_pc`+4.
- R3: A fetch address that matches an entry whose valid bit is clear yields `pred_kind` 00 and `pred_next_pc` = `fetch_pc`+4.
- R4: A match on a valid entry whose target is all zeros yields `pred_kind` 01 (taken, target unknown) and `pred_next_pc` = `fetch_pc`+4.
- R5: A match on a valid entry with a non-zero target yields `pred_kind` 10 (taken with target) and `pred_next_pc` equal to that target.
- R6: An update with `upd_killed` high changes no entry.
- R7: A live update whose address matches an entry sets that entry valid with the reported target when `upd_taken` is high, and clears its valid bit when `upd_taken` is low.
- R8: A live taken update that matches no entry writes the lowest-numbered invalid entry. A live not-taken update that matches no entry allocates nothing.
- R9: When all entries are valid, a taken miss replaces the entry at a rotating pointer that starts at entry 0 after reset and advances by one after each such replacement.
- R10: A lookup in the same cycle as an update to the same address returns the contents from before the update. The new contents are seen from the next cycle on.
- R11: With `init_en` high, entry `init_idx` is written with the given valid bit, tag and target at the clock edge, and the update port is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_kind | output | 2 | 00 none, 01 taken without target, 10 taken with target |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_en | input | 1 | Resolved branch or jump report |
| upd_killed | input | 1 | Reported instruction was killed |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved destination (zero means unknown) |
| init_en | input | 1 | Direct entry write |
| init_idx | input | 2 | Entry to write |
| init_valid | input | 1 | Valid bit to load |
| init_tag | input | 32 | Tag to load |
| init_target | input | 32 | Target to load |

## Verification
Lookups are tried on a missing tag, on a tag held in an invalid entry, on a valid entry with an empty target and on one with a stored target, so each of the three outcomes is told apart from the others. Updates are tried as killed, as taken or not-taken hits, and as taken and not-taken misses. A sequence of misses first fills the free entries and then evicts entries in rotation, which tells free-first choice apart from pure rotation. A lookup made in the same cycle as an update to the same address shows whether old or new contents are returned, and a load made together with an update shows which of the two wins.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int ADDR_W    = 32;
    localparam int N_ENTRIES = 4;

    typedef enum logic [1:0] {
        PRED_NONE    = 2'b00,
        PRED_TAKEN   = 2'b01,
        PRED_TARGET  = 2'b10
    } pred_kind_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] target;
    } btb_slot_t;

    function automatic logic [ADDR_W-1:0] seq_pc(input logic [ADDR_W-1:0] pc);
        return pc + ADDR_W'(4);
    endfunction

    function automatic logic target_empty(input logic [ADDR_W-1:0] t);
        return t == '0;
    endfunction

endpackage

// File: rtl/btb_victim.sv
module btb_victim
    import btb_pkg::*;
#(
    parameter int NE    = N_ENTRIES,
    localparam int IW   = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NE-1:0] valid_vec,
    input  logic          alloc_fire,
    output logic [IW-1:0] victim_idx
);

    logic [IW-1:0] rr_ptr;
    logic [IW-1:0] first_free;
    logic          any_free;

    always_comb begin
        any_free   = 1'b0;
        first_free = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free   = 1'b1;
                first_free = IW'(i);
            end
        end
    end

    assign victim_idx = any_free ? first_free : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (alloc_fire && !any_free) begin
            if (rr_ptr == IW'(NE - 1)) rr_ptr <= '0;
            else                       rr_ptr <= rr_ptr + 1'b1;
        end
    end

    // R8: a free entry, when one exists, is always the one offered
    assert_free_first_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_vec != '1) |-> !valid_vec[victim_idx]);

    // R9: pointer only moves when the buffer was full at allocation
    assert_rr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!alloc_fire || (valid_vec != '1)) |=> $stable(rr_ptr));

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int NE    = N_ENTRIES,
    localparam int IW   = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd_en,
    input  logic                  upd_killed,
    input  logic [ADDR_W-1:0]     upd_pc,
    input  logic                  upd_taken,
    input  logic [ADDR_W-1:0]     upd_target,
    input  logic                  init_en,
    input  logic [IW-1:0]         init_idx,
    input  logic                  init_valid,
    input  logic [ADDR_W-1:0]     init_tag,
    input  logic [ADDR_W-1:0]     init_target,
    input  logic [IW-1:0]         victim_idx,
    output logic                  alloc_fire,
    output logic [NE-1:0]         valid_vec,
    output btb_slot_t [NE-1:0]    slots
);

    logic          live;
    logic          hit;
    logic [IW-1:0] hit_idx;

    assign live = upd_en && !upd_killed && !init_en;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (slots[i].tag == upd_pc) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    assign alloc_fire = live && !hit && upd_taken;

    generate
        for (genvar g = 0; g < NE; g++) begin : g_valid
            assign valid_vec[g] = slots[g].valid;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NE; i++) begin
                slots[i] <= '0;
            end
        end else if (init_en) begin
            slots[init_idx].valid  <= init_valid;
            slots[init_idx].tag    <= init_tag;
            slots[init_idx].target <= init_target;
        end else if (live) begin
            if (hit) begin
                slots[hit_idx].valid <= upd_taken;
                if (upd_taken) slots[hit_idx].target <= upd_target;
            end else if (upd_taken) begin
                slots[victim_idx].valid  <= 1'b1;
                slots[victim_idx].tag    <= upd_pc;
                slots[victim_idx].target <= upd_target;
            end
        end
    end

    // R6: a killed report leaves every entry untouched
    assert_killed_inert_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_killed && !init_en) |=> (slots == $past(slots)));

    // R7: a not-taken hit leaves the matched entry invalid
    assert_nt_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (live && hit && !upd_taken) |=> !slots[$past(hit_idx)].valid);

    // R8: allocation lands a valid entry holding the reported address
    assert_alloc_lands_R8: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |=> (slots[$past(victim_idx)].valid &&
                        slots[$past(victim_idx)].tag == $past(upd_pc)));

    // R11: a load wins over any simultaneous report
    assert_init_wins_R11: assert property (@(posedge clk) disable iff (rst)
        init_en |=> (slots[$past(init_idx)].tag == $past(init_tag)));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int NE = N_ENTRIES
) (
    input  btb_slot_t [NE-1:0] slots,
    input  logic [ADDR_W-1:0]  fetch_pc,
    output pred_kind_e         kind,
    output logic [ADDR_W-1:0]  next_pc
);

    logic [NE-1:0]     match_vec;
    logic              any_match;
    btb_slot_t         picked;

    generate
        for (genvar g = 0; g < NE; g++) begin : g_cmp
            assign match_vec[g] = (slots[g].tag == fetch_pc);
        end
    endgenerate

    always_comb begin
        any_match = 1'b0;
        picked    = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_match = 1'b1;
                picked    = slots[i];
            end
        end
    end

    always_comb begin
        kind    = PRED_NONE;
        next_pc = seq_pc(fetch_pc);
        if (any_match && picked.valid) begin
            if (target_empty(picked.target)) begin
                kind = PRED_TAKEN;
            end else begin
                kind    = PRED_TARGET;
                next_pc = picked.target;
            end
        end
    end

endmodule

// File: rtl/btb_fa.sv
module btb_fa
    import btb_pkg::*;
#(
    parameter int NE    = N_ENTRIES,
    localparam int IW   = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [1:0]        pred_kind,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_en,
    input  logic              upd_killed,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              init_en,
    input  logic [IW-1:0]     init_idx,
    input  logic              init_valid,
    input  logic [ADDR_W-1:0] init_tag,
    input  logic [ADDR_W-1:0] init_target
);

    btb_slot_t [NE-1:0] slots;
    logic [NE-1:0]      valid_vec;
    logic [IW-1:0]      victim_idx;
    logic               alloc_fire;
    pred_kind_e         kind;

    btb_victim #(.NE(NE)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .alloc_fire (alloc_fire),
        .victim_idx (victim_idx)
    );

    btb_store #(.NE(NE)) u_store (
        .clk         (clk),
        .rst         (rst),
        .upd_en      (upd_en),
        .upd_killed  (upd_killed),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_target  (upd_target),
        .init_en     (init_en),
        .init_idx    (init_idx),
        .init_valid  (init_valid),
        .init_tag    (init_tag),
        .init_target (init_target),
        .victim_idx  (victim_idx),
        .alloc_fire  (alloc_fire),
        .valid_vec   (valid_vec),
        .slots       (slots)
    );

    btb_lookup #(.NE(NE)) u_lookup (
        .slots    (slots),
        .fetch_pc (fetch_pc),
        .kind     (kind),
        .next_pc  (pred_next_pc)
    );

    assign pred_kind = kind;

    // R4: no stored target is offered unless a target is predicted
    assert_seq_unless_target_R4: assert property (@(posedge clk) disable iff (rst)
        (pred_kind != 2'b10) |-> (pred_next_pc == fetch_pc + 32'd4));

    // R5: a target prediction never carries the empty value
    assert_target_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        (pred_kind == 2'b10) |-> (pred_next_pc != '0));

    // R1: the code 11 is never produced
    assert_kind_legal_R1: assert property (@(posedge clk) disable iff (rst)
        pred_kind != 2'b11);

endmodule

// File: tb/btb_fa_tb.sv
module btb_fa_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic [1:0]  pred_kind;
    logic [31:0] pred_next_pc;
    logic        upd_en = 1'b0, upd_killed = 1'b0, upd_taken = 1'b0;
    logic [31:0] upd_pc = '0, upd_target = '0;
    logic        init_en = 1'b0, init_valid = 1'b0;
    logic [1:0]  init_idx = '0;
    logic [31:0] init_tag = '0, init_target = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    btb_fa u_dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_kind(pred_kind), .pred_next_pc(pred_next_pc),
        .upd_en(upd_en), .upd_killed(upd_killed), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target),
        .init_en(init_en), .init_idx(init_idx), .init_valid(init_valid),
        .init_tag(init_tag), .init_target(init_target)
    );

    task automatic compare(input string req, input logic [1:0] ek, input logic [31:0] en);
        n_checks++;
        if (pred_kind !== ek || pred_next_pc !== en) begin
            n_fail++;
            $display("FAIL %s pc=%h kind=%b next=%h expected kind=%b next=%h",
                     req, fetch_pc, pred_kind, pred_next_pc, ek, en);
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc,
                        input logic [1:0] ek, input logic [31:0] en);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        compare(req, ek, en);
    endtask

    task automatic report(input logic [31:0] pc, input logic tk,
                          input logic [31:0] tgt, input logic killed);
        @(negedge clk);
        upd_en = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_killed = killed;
        @(negedge clk);
        upd_en = 1'b0; upd_killed = 1'b0;
    endtask

    task automatic load(input logic [1:0] idx, input logic v,
                        input logic [31:0] tag, input logic [31:0] tgt);
        @(negedge clk);
        init_en = 1'b1; init_idx = idx; init_valid = v; init_tag = tag; init_target = tgt;
        @(negedge clk);
        init_en = 1'b0;
    endtask

    task automatic t_reset;
        look("R1", 32'h2004, 2'b00, 32'h2008);
        look("R1", 32'h0000, 2'b00, 32'h0004);
    endtask

    task automatic t_load_and_lookup;
        load(2'd0, 1'b0, 32'h2004, 32'h4008);
        load(2'd1, 1'b1, 32'h2008, 32'h0000);
        load(2'd2, 1'b1, 32'h4004, 32'h2004);
        look("R3", 32'h2004, 2'b00, 32'h2008);
        look("R4", 32'h2008, 2'b01, 32'h200c);
        look("R5", 32'h4004, 2'b10, 32'h2004);
        look("R2", 32'h3000, 2'b00, 32'h3004);
    endtask

    task automatic t_killed;
        report(32'h2008, 1'b0, 32'h0, 1'b1);
        look("R6", 32'h2008, 2'b01, 32'h200c);
        report(32'h4004, 1'b1, 32'h1110, 1'b1);
        look("R6", 32'h4004, 2'b10, 32'h2004);
    endtask

    task automatic t_hit_update;
        report(32'h2004, 1'b1, 32'h4008, 1'b0);
        look("R7", 32'h2004, 2'b10, 32'h4008);
        report(32'h2008, 1'b0, 32'h0, 1'b0);
        look("R7", 32'h2008, 2'b00, 32'h200c);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        fetch_pc = 32'h4004;
        upd_en = 1'b1; upd_pc = 32'h4004; upd_taken = 1'b1; upd_target = 32'h4444;
        #1;
        compare("R10 old", 2'b10, 32'h2004);
        @(negedge clk);
        upd_en = 1'b0;
        #1;
        compare("R10 new", 2'b10, 32'h4444);
    endtask

    task automatic t_alloc;
        report(32'h7000, 1'b0, 32'h0, 1'b0);
        look("R8 nt miss", 32'h7000, 2'b00, 32'h7004);
        report(32'h5000, 1'b1, 32'h6000, 1'b0);
        report(32'h5100, 1'b1, 32'h6100, 1'b0);
        look("R8", 32'h5000, 2'b10, 32'h6000);
        look("R8", 32'h5100, 2'b10, 32'h6100);
        look("R8 kept", 32'h2004, 2'b10, 32'h4008);
        look("R8 kept", 32'h4004, 2'b10, 32'h4444);
    endtask

    task automatic t_rotate;
        report(32'h5200, 1'b1, 32'h6200, 1'b0);
        look("R9", 32'h2004, 2'b00, 32'h2008);
        look("R9", 32'h5200, 2'b10, 32'h6200);
        report(32'h5300, 1'b1, 32'h6300, 1'b0);
        look("R9", 32'h5000, 2'b00, 32'h5004);
        look("R9", 32'h5300, 2'b10, 32'h6300);
        look("R9 kept", 32'h4004, 2'b10, 32'h4444);
    endtask

    task automatic t_empty_target;
        report(32'h5100, 1'b1, 32'h0, 1'b0);
        look("R4 upd", 32'h5100, 2'b01, 32'h5104);
    endtask

    task automatic t_load_priority;
        @(negedge clk);
        init_en = 1'b1; init_idx = 2'd2; init_valid = 1'b1;
        init_tag = 32'hA000; init_target = 32'hB000;
        upd_en = 1'b1; upd_pc = 32'h5100; upd_taken = 1'b0; upd_killed = 1'b0;
        @(negedge clk);
        init_en = 1'b0; upd_en = 1'b0;
        look("R11", 32'hA000, 2'b10, 32'hB000);
        look("R11", 32'h4004, 2'b00, 32'h4008);
        look("R11", 32'h5100, 2'b01, 32'h5104);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_and_lookup();
        t_killed();
        t_hit_update();
        t_same_cycle();
        t_alloc();
        t_rotate();
        t_empty_target();
        t_load_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule